// File: doc/BRIEF.md
# Serial Encoder Link Bring-Up Sequencer

This block is the master-side controller that takes a two-wire serial position-encoder link from power-up to an established link. It walks a fixed chain of phases: reset, sync, learn, learn-confirm, line check and identity request. In every phase it presents a parameter code to a frame transmitter and counts completed frames until that phase's repetition count is reached. The serializer, the line coding and the receive front end sit outside the block. They report back through one frame-done strobe, which carries a pass/fail verdict from the pattern comparator, the delay measured by the delay search, and the 40-bit decoded identity reply.

The block keeps the last delay found during the learn phase. It commits that delay to the delay register only when every learn-confirm and line-check frame has passed. The identity reply has a byte-mirrored layout, and the block validates that layout before it stores the identity. It then derives the accuracy and single-turn bit counts and a position mask from the identity, raises the link flags and stops requesting frames. Any failed frame sends the sequencer back to the reset phase. A failure also bumps a reset counter, sets a sticky protocol-reset event and, if enabled, pulses an interrupt request.

Top module: `link_bringup_seq`

## Requirements
- R1: After synchronous reset the block requests frames (tx_req=1) with code 1. link_up, drive_sync, prst_event, irq, rst_count and delay_reg are 0, and qm_level is 8.
- R2: The phases run in a fixed order, and none is ever skipped. The codes and frame counts are: reset code 1 ×2, sync code 2 ×16, learn code 3 ×9, learn-confirm code 4 ×9, line-check code 5 ×16, identity request code 6 ×1.
- R3: A frame is counted only on a tx_done pulse. While tx_done is low, the code and phase do not change.
- R4: During the learn phase, each passing frame captures res_delay. The value from the last learn frame is the one kept.
- R5: delay_reg changes only when the final line-check frame passes, and it then takes the kept learn delay. An earlier abort leaves delay_reg unchanged.
- R6: A frame with res_pass=0 in the learn, learn-confirm or line-check phase is a failure. In the cycle after the frame, the code returns to 1, rst_count has risen by one (wrapping at its width), and prst_event is 1.
- R7: On a failure, irq pulses high for exactly one cycle when irq_en was 1 at the failing frame. Otherwise irq stays 0.
- R8: An identity reply with bytes b0..b4 (b0 = id_word[7:0]) is accepted only if b0==b3, b1==b4 and b2[3:0]==b2[7:4]. Any other reply is a failure, handled as in R6.
- R9: When a reply is accepted, enc_id becomes {b2,b1,b0}, link_up and drive_sync become 1, qm_level is 8 and tx_req drops to 0. Later tx_done pulses change none of these outputs.
- R10: When a reply is accepted, the block computes three values from f = enc_id. acc_bits = f[3:0]+8. st_bits = f[9:4]+acc_bits−mt_bits. pos_mask holds (st_bits+mt_bits) low ones, and is all ones when that total is 40 or more.
- R11: prst_event stays set until event_clr is asserted. A new failure in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_req | output | 1 | A frame of the current phase is wanted |
| tx_code | output | 4 | Parameter code to transmit |
| tx_done | input | 1 | One-cycle frame completion strobe with results |
| res_pass | input | 1 | Test-pattern compare (or delay search) passed |
| res_delay | input | DLY_W | Delay found by the search for this frame |
| id_word | input | 40 | Decoded identity reply |
| mt_bits | input | BIT_W | Multi-turn bit count |
| irq_en | input | 1 | Interrupt enable for the protocol-reset event |
| event_clr | input | 1 | Clears the protocol-reset event |
| link_up | output | 1 | Link established |
| drive_sync | output | 1 | Drive-cycle synchronization enabled |
| qm_level | output | 4 | Quality monitor level |
| rst_count | output | CNT_W | Number of protocol restarts |
| prst_event | output | 1 | Sticky protocol-reset event |
| irq | output | 1 | Interrupt pulse |
| delay_reg | output | DLY_W | Committed slave delay |
| enc_id | output | 24 | Stored encoder identity |
| acc_bits | output | BIT_W | Accuracy bit count |
| st_bits | output | BIT_W | Single-turn bit count |
| pos_mask | output | MASK_W | Position mask |

## Verification
A wrong phase or repetition count shows on tx_code within one frame. The code sequence drifts from the 2/16/9/9/16/1 cadence at the first wrong boundary. A fault in the abort path shows in the cycle after the failing frame, as a code other than 1, a rst_count that did not step, or an irq that disagrees with irq_en. A fault in the delay bookkeeping stays hidden until the final line-check frame, where delay_reg is compared with the last learn delay. A fault in identity decoding shows on link_up and on the derived field outputs right after the identity frame.

// File: rtl/lbs_pkg.sv
// Package: phase encoding and per-phase constants for the link bring-up sequencer.
// Assumes phases are visited strictly in declaration order.
package lbs_pkg;

    typedef enum logic [2:0] {
        PH_RESET, PH_SYNC, PH_LEARN, PH_CONFIRM, PH_CHECK, PH_IDREQ, PH_LINKED
    } phase_t;

    localparam int CODE_W = 4;

    // Parameter code sent in each phase
    function automatic logic [CODE_W-1:0] phase_code(phase_t p);
        case (p)
            PH_RESET:   return 4'd1;
            PH_SYNC:    return 4'd2;
            PH_LEARN:   return 4'd3;
            PH_CONFIRM: return 4'd4;
            PH_CHECK:   return 4'd5;
            PH_IDREQ:   return 4'd6;
            default:    return 4'd0;
        endcase
    endfunction

    // Successor phase; the linked phase is terminal
    function automatic phase_t next_phase(phase_t p);
        case (p)
            PH_RESET:   return PH_SYNC;
            PH_SYNC:    return PH_LEARN;
            PH_LEARN:   return PH_CONFIRM;
            PH_CONFIRM: return PH_CHECK;
            PH_CHECK:   return PH_IDREQ;
            default:    return PH_LINKED;
        endcase
    endfunction

    // Phases whose frames must pass the pattern compare
    function automatic logic needs_pattern(phase_t p);
        return (p == PH_LEARN) || (p == PH_CONFIRM) || (p == PH_CHECK);
    endfunction

endpackage

// File: rtl/lbs_rep_count.sv
// Repetition counter: counts accepted frames within a phase and flags the last one.
// Assumes limit >= 1 and that clear is raised when the phase changes.
module lbs_rep_count #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt;

    // Count frames, restart at phase boundaries
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (step)       cnt <= cnt + 1'b1;
    end

    // Current frame is the final repetition
    always_comb last = (cnt == limit - 1'b1);
endmodule

// File: rtl/lbs_id_decode.sv
// Identity decoder: checks the byte-mirrored reply layout and derives bit counts and mask.
// Assumes MASK_W fits in BIT_W bits.
module lbs_id_decode #(
    parameter int BIT_W  = 8,
    parameter int MASK_W = 40
) (
    input  logic [39:0]       id_word,
    input  logic [BIT_W-1:0]  mt_bits,
    output logic              id_ok,
    output logic [23:0]       id_field,
    output logic [BIT_W-1:0]  acc_n,
    output logic [BIT_W-1:0]  st_n,
    output logic [MASK_W-1:0] mask
);
    logic [BIT_W-1:0] total;
    logic [BIT_W-1:0] shamt;

    // Mirror check: outer byte pairs and middle nibbles must match
    always_comb begin
        id_ok = (id_word[7:0]   == id_word[31:24]) &&
                (id_word[15:8]  == id_word[39:32]) &&
                (id_word[19:16] == id_word[23:20]);
        id_field = id_word[23:0];
    end

    // Bit counts and position mask from the identity field
    always_comb begin
        acc_n = BIT_W'(id_field[3:0]) + BIT_W'(8);
        st_n  = BIT_W'(id_field[9:4]) + acc_n - mt_bits;
        total = st_n + mt_bits;
        shamt = BIT_W'(MASK_W) - total;
        if (total >= BIT_W'(MASK_W)) mask = '1;
        else                         mask = {MASK_W{1'b1}} >> shamt;
    end
endmodule

// File: rtl/lbs_event.sv
// Restart bookkeeping: reset counter, sticky protocol-reset event and gated interrupt pulse.
// Assumes fail is a single-cycle pulse.
module lbs_event #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fail,
    input  logic             irq_en,
    input  logic             event_clr,
    output logic [CNT_W-1:0] rst_count,
    output logic             prst_event,
    output logic             irq
);
    // Count restarts, hold the event until cleared, pulse the interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_count  <= '0;
            prst_event <= 1'b0;
            irq        <= 1'b0;
        end else begin
            irq <= fail & irq_en;
            if (fail) begin
                rst_count  <= rst_count + 1'b1;
                prst_event <= 1'b1;
            end else if (event_clr) begin
                prst_event <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/link_bringup_seq.sv
// Link bring-up sequencer: steps through reset, sync, learn, confirm, check and identity
// phases, commits delay and identity, and restarts on any failed frame.
// Assumes tx_done is a one-cycle strobe with res_pass/res_delay/id_word valid alongside it.
module link_bringup_seq
    import lbs_pkg::*;
#(
    parameter int N_RESET   = 2,
    parameter int N_SYNC    = 16,
    parameter int N_LEARN   = 9,
    parameter int N_CONFIRM = 9,
    parameter int N_CHECK   = 16,
    parameter int DLY_W     = 8,
    parameter int CNT_W     = 8,
    parameter int BIT_W     = 8,
    parameter int MASK_W    = 40,
    parameter int QM_INIT   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              tx_req,
    output logic [3:0]        tx_code,
    input  logic              tx_done,
    input  logic              res_pass,
    input  logic [DLY_W-1:0]  res_delay,
    input  logic [39:0]       id_word,
    input  logic [BIT_W-1:0]  mt_bits,
    input  logic              irq_en,
    input  logic              event_clr,
    output logic              link_up,
    output logic              drive_sync,
    output logic [3:0]        qm_level,
    output logic [CNT_W-1:0]  rst_count,
    output logic              prst_event,
    output logic              irq,
    output logic [DLY_W-1:0]  delay_reg,
    output logic [23:0]       enc_id,
    output logic [BIT_W-1:0]  acc_bits,
    output logic [BIT_W-1:0]  st_bits,
    output logic [MASK_W-1:0] pos_mask
);
    localparam int MAX_A = (N_RESET > N_SYNC) ? N_RESET : N_SYNC;
    localparam int MAX_B = (N_LEARN > N_CONFIRM) ? N_LEARN : N_CONFIRM;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_N = (MAX_C > N_CHECK) ? MAX_C : N_CHECK;
    localparam int REP_W = $clog2(MAX_N + 1);

    phase_t            phase;
    logic [REP_W-1:0]  limit;
    logic              last;
    logic              frame_ev;
    logic              fail;
    logic [DLY_W-1:0]  delay_meas;
    logic              id_ok;
    logic [23:0]       id_field;
    logic [BIT_W-1:0]  acc_n;
    logic [BIT_W-1:0]  st_n;
    logic [MASK_W-1:0] mask_n;

    // Repetition limit of the current phase
    always_comb begin
        case (phase)
            PH_RESET:   limit = REP_W'(N_RESET);
            PH_SYNC:    limit = REP_W'(N_SYNC);
            PH_LEARN:   limit = REP_W'(N_LEARN);
            PH_CONFIRM: limit = REP_W'(N_CONFIRM);
            PH_CHECK:   limit = REP_W'(N_CHECK);
            default:    limit = REP_W'(1);
        endcase
    end

    // Frame completion and failure qualification
    always_comb begin
        frame_ev = tx_done && (phase != PH_LINKED);
        fail     = frame_ev && ((needs_pattern(phase) && !res_pass) ||
                                ((phase == PH_IDREQ) && !id_ok));
        tx_req   = (phase != PH_LINKED);
        tx_code  = phase_code(phase);
    end

    lbs_rep_count #(.W(REP_W)) i_rep (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (frame_ev && (fail || last)),
        .step  (frame_ev && !fail && !last),
        .limit (limit),
        .last  (last)
    );

    lbs_id_decode #(.BIT_W(BIT_W), .MASK_W(MASK_W)) i_id (
        .id_word  (id_word),
        .mt_bits  (mt_bits),
        .id_ok    (id_ok),
        .id_field (id_field),
        .acc_n    (acc_n),
        .st_n     (st_n),
        .mask     (mask_n)
    );

    lbs_event #(.CNT_W(CNT_W)) i_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .fail       (fail),
        .irq_en     (irq_en),
        .event_clr  (event_clr),
        .rst_count  (rst_count),
        .prst_event (prst_event),
        .irq        (irq)
    );

    // Phase register: advance after the last repetition, restart on failure
    always_ff @(posedge clk) begin
        if (!rst_n || fail)          phase <= PH_RESET;
        else if (frame_ev && last)   phase <= next_phase(phase);
    end

    // Delay capture during learn and commit after the final line check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delay_meas <= '0;
            delay_reg  <= '0;
        end else begin
            if (frame_ev && phase == PH_LEARN && res_pass)
                delay_meas <= res_delay;
            if (frame_ev && phase == PH_CHECK && last && res_pass)
                delay_reg <= delay_meas;
        end
    end

    // Identity store and link flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_id     <= '0;
            acc_bits   <= '0;
            st_bits    <= '0;
            pos_mask   <= '0;
            link_up    <= 1'b0;
            drive_sync <= 1'b0;
            qm_level   <= 4'(QM_INIT);
        end else if (fail) begin
            link_up    <= 1'b0;
            drive_sync <= 1'b0;
            qm_level   <= 4'(QM_INIT);
        end else if (frame_ev && phase == PH_IDREQ) begin
            enc_id     <= id_field;
            acc_bits   <= acc_n;
            st_bits    <= st_n;
            pos_mask   <= mask_n;
            link_up    <= 1'b1;
            drive_sync <= 1'b1;
            qm_level   <= 4'(QM_INIT);
        end
    end
endmodule

// File: rtl/lbs_checker.sv
// Checker: temporal properties of the bring-up sequencer, observed at its ports.
// Assumes codes 3..5 are the pattern-checked phases and 1 the reset phase.
module lbs_checker #(
    parameter int DLY_W = 8,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_req,
    input logic [3:0]       tx_code,
    input logic             tx_done,
    input logic             res_pass,
    input logic [39:0]      id_word,
    input logic             irq_en,
    input logic             event_clr,
    input logic             link_up,
    input logic [CNT_W-1:0] rst_count,
    input logic             prst_event,
    input logic             irq,
    input logic [DLY_W-1:0] delay_reg
);
    a_r3_hold_without_done: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_done |=> $stable(tx_code));

    a_r5_delay_only_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_done |=> $stable(delay_reg));

    a_r6_fail_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && tx_req && !res_pass && tx_code >= 4'd3 && tx_code <= 4'd5)
        |=> (tx_code == 4'd1 && prst_event && rst_count == $past(rst_count) + 1'b1));

    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_en));

    a_r8_bad_id_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && tx_code == 4'd6 && id_word[7:0] != id_word[31:24])
        |=> (!link_up && tx_code == 4'd1));

    a_r9_linked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |-> !tx_req);

    a_r11_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_event && !event_clr) |=> prst_event);
endmodule

bind link_bringup_seq lbs_checker #(.DLY_W(DLY_W), .CNT_W(CNT_W)) i_lbs_checker (.*);

// File: tb/test_link_bringup_seq.sv
module test_link_bringup_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_req;
    logic [3:0]  tx_code;
    logic        tx_done = 1'b0;
    logic        res_pass = 1'b0;
    logic [7:0]  res_delay = '0;
    logic [39:0] id_word = '0;
    logic [7:0]  mt_bits = '0;
    logic        irq_en = 1'b0;
    logic        event_clr = 1'b0;
    logic        link_up, drive_sync, prst_event, irq;
    logic [3:0]  qm_level;
    logic [7:0]  rst_count, delay_reg, acc_bits, st_bits;
    logic [23:0] enc_id;
    logic [39:0] pos_mask;

    int n_chk = 0;
    int n_bad = 0;
    int exp_rc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    link_bringup_seq i_link_bringup_seq (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Expected code for frame index i of a full bring-up (R2)
    function automatic logic [3:0] exp_code(int i);
        if (i < 2)  return 4'd1;
        if (i < 18) return 4'd2;
        if (i < 27) return 4'd3;
        if (i < 36) return 4'd4;
        if (i < 52) return 4'd5;
        return 4'd6;
    endfunction

    function automatic logic [39:0] make_id(logic [7:0] b0, logic [7:0] b1, logic [3:0] n);
        return {b1, b0, n, n, b1, b0};
    endfunction

    function automatic logic [39:0] exp_mask(int total);
        if (total >= 40) return '1;
        return (40'h1 << total) - 40'h1;
    endfunction

    task automatic frame(input bit pass, input logic [7:0] d, input logic [39:0] idw);
        res_pass  = pass;
        res_delay = d;
        id_word   = idw;
        tx_done   = 1'b1;
        @(negedge clk);
        tx_done   = 1'b0;
    endtask

    // One bring-up attempt; fail_at < 0 means all pattern frames pass
    task automatic run(input int fail_at, input logic [39:0] idw, input bit id_good);
        logic [7:0] old_d = delay_reg;
        logic [7:0] last_d = '0;
        for (int i = 0; i < 53; i++) begin
            logic [7:0] d = 8'($urandom);
            chk(tx_code == exp_code(i) && tx_req, "R2", {tx_req, tx_code}, {1'b1, exp_code(i)});
            if (i >= 18 && i < 27) last_d = d;
            frame(i != fail_at, d, idw);
            if (i == fail_at || (i == 52 && !id_good)) begin
                chk(tx_code == 4'd1, (i == 52) ? "R8" : "R6", tx_code, 4'd1);
                chk(rst_count == 8'(exp_rc + 1), "R6", rst_count, 8'(exp_rc + 1));
                chk(prst_event == 1'b1, "R6", prst_event, 1);
                chk(irq == irq_en, "R7", irq, irq_en);
                chk(link_up == 1'b0, "R8", link_up, 0);
                if (i < 52) chk(delay_reg == old_d, "R5", delay_reg, old_d);
                exp_rc++;
                @(negedge clk);
                chk(irq == 1'b0, "R7", irq, 0);
                return;
            end
            if (i == 50) chk(delay_reg == old_d, "R5", delay_reg, old_d);
            if (i == 51) chk(delay_reg == last_d, "R4", delay_reg, last_d);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        logic [7:0] b0, b1;
        logic [39:0] good;
        int total;
        void'($urandom(32'd4711));
        mt_bits = 8'd4;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(tx_req && tx_code == 4'd1, "R1", tx_code, 1);
        chk(!link_up && !drive_sync && !prst_event && !irq, "R1", {link_up, drive_sync, prst_event, irq}, 0);
        chk(rst_count == 0 && delay_reg == 0 && qm_level == 4'd8, "R1", {rst_count, delay_reg, qm_level}, 8);
        // R3: no strobe, no progress
        repeat (6) @(negedge clk);
        chk(tx_code == 4'd1, "R3", tx_code, 1);

        b0 = 8'h3a; b1 = 8'h01;
        good = make_id(b0, b1, 4'h7);

        // Directed aborts: first learn frame, last check frame
        irq_en = 1'b1; run(18, good, 1);
        irq_en = 1'b0; run(51, good, 1);
        // R11: event sticky, clear drops it
        repeat (3) @(negedge clk);
        chk(prst_event == 1'b1, "R11", prst_event, 1);
        event_clr = 1'b1; @(negedge clk); event_clr = 1'b0;
        chk(prst_event == 1'b0, "R11", prst_event, 0);
        // Random aborts
        for (int k = 0; k < 5; k++) begin
            irq_en = 1'($urandom);
            run(18 + int'($urandom % 34), good, 1);
        end
        // R8: each mirror condition broken
        run(-1, good ^ 40'h00_01_00_00_00, 0);
        run(-1, good ^ 40'h01_00_00_00_00, 0);
        run(-1, good ^ 40'h00_00_01_00_00, 0);
        // Full good bring-up with a random identity
        b0 = 8'($urandom); b1 = 8'($urandom);
        good = make_id(b0, b1, 4'($urandom));
        run(-1, good, 1);
        chk(link_up && drive_sync && !tx_req, "R9", {link_up, drive_sync, tx_req}, 3'b110);
        chk(enc_id == good[23:0] && qm_level == 4'd8, "R9", enc_id, good[23:0]);
        chk(acc_bits == 8'(b0[3:0]) + 8'd8, "R10", acc_bits, 8'(b0[3:0]) + 8'd8);
        total = int'({b1[1:0], b0[7:4]}) + int'(b0[3:0]) + 8;
        chk(st_bits == 8'(total - 4), "R10", st_bits, 8'(total - 4));
        chk(pos_mask == exp_mask(total), "R10", pos_mask, exp_mask(total));
        // R9: later strobes ignored
        frame(1'b0, 8'h55, 40'h0);
        chk(link_up && !tx_req && rst_count == 8'(exp_rc), "R9", rst_count, 8'(exp_rc));
        // R10 boundary: total >= 40 gives full mask
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; exp_rc = 0;
        good = make_id(8'hff, 8'h03, 4'h0);
        run(-1, good, 1);
        chk(pos_mask == '1, "R10", pos_mask, 40'hff_ffff_ffff);
        finish_up();
    end
endmodule